// File: doc/BRIEF.md
# Aliased Sub-Register File

A bank of eight 32-bit general-purpose registers whose low 16 bits can also be reached as a halfword, and whose halfword can be reached again as two separate bytes. Any register may hold data or an address. Nothing in the bank ties a register to one kind of content.

The block has two combinational read ports and one write port that updates on the clock edge. Every port takes a register index and a two-bit view selector. The selector chooses the whole word, the low halfword, the low byte, or the upper byte of the low halfword.

A narrow write merges its field into the chosen lane and keeps every other bit of the register. A narrow read returns the field right-justified with zeros above it. A core datapath uses the block for operand fetch and result writeback at any operand size.

Top module: `gpr_alias_file`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, all eight 32-bit registers become zero.
- R2: With `wr_en` high and `wr_sel` = 2'b00, the addressed register takes all 32 bits of `wr_data` at the rising edge.
- R3: With `wr_sel` = 2'b01, bits 15:0 of the addressed register take `wr_data[15:0]`, and bits 31:16 keep their value.
- R4: With `wr_sel` = 2'b10, bits 7:0 of the addressed register take `wr_data[7:0]`, and bits 31:8 keep their value.
- R5: With `wr_sel` = 2'b11, bits 15:8 of the addressed register take `wr_data[7:0]`, and bits 31:16 and 7:0 keep their value. For example, 0x3A3F901D becomes 0x3A3F441D when 0x44 is written.
- R6: A write changes only the register named by `wr_idx`. While `wr_en` is low, no register changes.
- R7: A read with selector 2'b00 returns the full 32-bit register content.
- R8: Narrow reads return the selected field right-justified and zero-extended. Selector 2'b01 returns bits 15:0, and 2'b10 returns bits 7:0. Selector 2'b11 returns bits 15:8, moved down to bits 7:0.
- R9: The two read ports are combinational and independent. Each port follows only its own index and selector.
- R10: A read of the register being written in the same cycle returns the old value. The new value is seen only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register index for the write |
| wr_sel | input | 2 | Write view selector (00 word, 01 half, 10 low byte, 11 high byte) |
| wr_data | input | 32 | Write data; narrow fields are taken right-justified |
| ra_idx | input | 3 | Read port A register index |
| ra_sel | input | 2 | Read port A view selector |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 3 | Read port B register index |
| rb_sel | input | 2 | Read port B view selector |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
A write shows up at the read ports one rising edge after it is presented. The reads themselves respond in the same cycle, with no register between the index and the data.

The bench changes inputs on the falling edge and samples read data 1 ns later. Each sample therefore reflects the register state left by the most recent rising edge. Writes are held across exactly one rising edge before reads check the result.

For the no-bypass case, the bench samples once before the edge to see the old value and once after it to see the new one.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;
  parameter int GPR_W  = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    VIEW_WORD = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_LO8  = 2'b10,
    VIEW_HI8  = 2'b11
  } gpr_view_e;

  // Bits of the register covered by a view
  function automatic logic [GPR_W-1:0] view_mask(input gpr_view_e v);
    logic [GPR_W-1:0] m;
    case (v)
      VIEW_WORD: m = '1;
      VIEW_HALF: m = {{(GPR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      VIEW_LO8:  m = {{(GPR_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      default:   m = {{(GPR_W-HALF_W){1'b0}}, {BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
    endcase
    return m;
  endfunction

  // Moves right-justified write data into its lane position
  function automatic logic [GPR_W-1:0] view_place(input gpr_view_e v,
                                                  input logic [GPR_W-1:0] d);
    logic [GPR_W-1:0] p;
    if (v == VIEW_HI8) p = {{(GPR_W-HALF_W){1'b0}}, d[BYTE_W-1:0], {BYTE_W{1'b0}}};
    else               p = d & view_mask(v);
    return p;
  endfunction

  // Extracts a view from a full word, right-justified and zero-extended
  function automatic logic [GPR_W-1:0] view_extract(input gpr_view_e v,
                                                    input logic [GPR_W-1:0] w);
    logic [GPR_W-1:0] r;
    if (v == VIEW_HI8) r = {{(GPR_W-BYTE_W){1'b0}}, w[HALF_W-1:BYTE_W]};
    else               r = w & view_mask(v);
    return r;
  endfunction
endpackage

// File: rtl/gpr_lane_merge.sv
module gpr_lane_merge
  import gpr_alias_pkg::*;
(
  input  logic [GPR_W-1:0] old_word,
  input  logic [GPR_W-1:0] in_data,
  input  logic [1:0]       sel,
  output logic [GPR_W-1:0] new_word
);
  gpr_view_e        view;
  logic [GPR_W-1:0] mask;
  logic [GPR_W-1:0] placed;

  always_comb begin
    view     = gpr_view_e'(sel);
    mask     = view_mask(view);
    placed   = view_place(view, in_data);
    new_word = (old_word & ~mask) | (placed & mask);
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*GPR_W-1:0] bank_flat,
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                sel,
  output logic [GPR_W-1:0]          rd_data
);
  logic [GPR_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) word = bank_flat[i*GPR_W +: GPR_W];
    end
    rd_data = view_extract(gpr_view_e'(sel), word);
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_sel,
  input  logic [GPR_W-1:0] wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_sel,
  output logic [GPR_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_sel,
  output logic [GPR_W-1:0] rb_data
);
  logic [NUM_REGS*GPR_W-1:0] bank_flat;   // all registers, register i at [i*GPR_W +: GPR_W]
  logic [NUM_REGS-1:0]       wr_hit;      // one-hot write strobe per register
  logic [GPR_W-1:0]          wr_old_word; // current content of the write target
  logic [GPR_W-1:0]          wr_merged;   // target content after lane merge

  // Fetch target word through a word-view port, then merge the lane
  gpr_read_port #(.NUM_REGS(NUM_REGS)) u_wr_view (
    .bank_flat (bank_flat),
    .idx       (wr_idx),
    .sel       (2'b00),
    .rd_data   (wr_old_word)
  );

  gpr_lane_merge u_merge (
    .old_word (wr_old_word),
    .in_data  (wr_data),
    .sel      (wr_sel),
    .new_word (wr_merged)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)            bank_flat[g*GPR_W +: GPR_W] <= '0;
      else if (wr_hit[g]) bank_flat[g*GPR_W +: GPR_W] <= wr_merged;
    end
  end

  gpr_read_port #(.NUM_REGS(NUM_REGS)) u_port_a (
    .bank_flat (bank_flat),
    .idx       (ra_idx),
    .sel       (ra_sel),
    .rd_data   (ra_data)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS)) u_port_b (
    .bank_flat (bank_flat),
    .idx       (rb_idx),
    .sel       (rb_sel),
    .rd_data   (rb_data)
  );
endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic [1:0]                wr_sel,
  input logic [GPR_W-1:0]          wr_data,
  input logic [1:0]                ra_sel,
  input logic [GPR_W-1:0]          ra_data,
  input logic [1:0]                rb_sel,
  input logic [GPR_W-1:0]          rb_data,
  input logic [NUM_REGS-1:0]       wr_hit,
  input logic [NUM_REGS*GPR_W-1:0] bank_flat
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bank_flat == '0);                                       // R1
  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit) && (wr_en || wr_hit == '0));                          // R6
  AST_READ_A_HI8_ZX: assert property (@(posedge clk) disable iff (rst)
    ra_sel == 2'b11 |-> ra_data[GPR_W-1:BYTE_W] == '0);                    // R8
  AST_READ_B_HALF_ZX: assert property (@(posedge clk) disable iff (rst)
    rb_sel == 2'b01 |-> rb_data[GPR_W-1:HALF_W] == '0);                    // R8

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[g] |=> $stable(bank_flat[g*GPR_W +: GPR_W]));                // R6
    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] && wr_sel == 2'b00 |=> bank_flat[g*GPR_W +: GPR_W] == $past(wr_data)); // R2
    AST_HALF_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] && wr_sel == 2'b01 |=> $stable(bank_flat[g*GPR_W+HALF_W +: GPR_W-HALF_W])); // R3
    AST_LO8_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] && wr_sel == 2'b10 |=> $stable(bank_flat[g*GPR_W+BYTE_W +: GPR_W-BYTE_W])); // R4
    AST_HI8_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] && wr_sel == 2'b11 |=> $stable(bank_flat[g*GPR_W+HALF_W +: GPR_W-HALF_W])
        && $stable(bank_flat[g*GPR_W +: BYTE_W]));                         // R5
  end
endmodule

bind gpr_alias_file gpr_alias_file_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .ra_sel    (ra_sel),
  .ra_data   (ra_data),
  .rb_sel    (rb_sel),
  .rb_data   (rb_data),
  .wr_hit    (wr_hit),
  .bank_flat (bank_flat)
);

// File: tb/gpr_alias_file_test.sv
`timescale 1ns/1ps
module gpr_alias_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  ra_idx = '0;
  logic [1:0]  ra_sel = '0;
  logic [31:0] ra_data;
  logic [2:0]  rb_idx = '0;
  logic [1:0]  rb_sel = '0;
  logic [31:0] rb_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] mdl [8];

  always #2.5 clk = ~clk;

  gpr_alias_file uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_data(wr_data), .ra_idx(ra_idx), .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_sel(rb_sel), .rb_data(rb_data)
  );

  // Expected merge, written with shifts by byte position
  function automatic logic [31:0] exp_merge(logic [31:0] old, logic [1:0] s, logic [31:0] d);
    case (s)
      2'b00: return d;
      2'b01: return {old[31:16], d[15:0]};
      2'b10: return {old[31:8], d[7:0]};
      default: return (old & 32'hFFFF_00FF) | ({24'h0, d[7:0]} << 8);
    endcase
  endfunction

  function automatic logic [31:0] exp_view(logic [31:0] w, logic [1:0] s);
    case (s)
      2'b00: return w;
      2'b01: return w % 32'h1_0000;
      2'b10: return w % 32'h100;
      default: return (w / 32'h100) % 32'h100;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] i, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[i] = exp_merge(mdl[i], s, d);
  endtask

  task automatic rd_a(string tag, logic [2:0] i, logic [1:0] s);
    ra_idx = i; ra_sel = s;
    #1;
    check(tag, ra_data, exp_view(mdl[i], s));
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) mdl[k] = 32'hDEAD_0000 + k;
    for (int k = 0; k < 8; k++) wr(3'(k), 2'b00, mdl[k]);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      mdl[k] = '0;
      rd_a("R1 reset clears", 3'(k), 2'b00);
    end
  endtask

  task automatic t_word;
    wr(3'd2, 2'b00, 32'hCAFE_F00D);
    rd_a("R2 word write", 3'd2, 2'b00);
    rd_a("R7 word read", 3'd2, 2'b00);
  endtask

  task automatic t_half;
    wr(3'd3, 2'b00, 32'h1234_5678);
    wr(3'd3, 2'b01, 32'hFFFF_ABCD);
    check("R3 half write keeps top", mdl[3], 32'h1234_ABCD);
    rd_a("R3 half merge", 3'd3, 2'b00);
    rd_a("R8 half read", 3'd3, 2'b01);
  endtask

  task automatic t_bytes;
    wr(3'd1, 2'b00, 32'h3A3F_901D);
    wr(3'd1, 2'b11, 32'h0000_0044);
    check("R5 example", mdl[1], 32'h3A3F_441D);
    rd_a("R5 high byte merge", 3'd1, 2'b00);
    rd_a("R8 high byte read", 3'd1, 2'b11);
    wr(3'd1, 2'b10, 32'hFFFF_FF77);
    rd_a("R4 low byte merge", 3'd1, 2'b00);
    rd_a("R8 low byte read", 3'd1, 2'b10);
  endtask

  task automatic t_isolation;
    wr(3'd5, 2'b00, 32'h5555_5555);
    wr(3'd6, 2'b00, 32'h6666_6666);
    wr(3'd5, 2'b11, 32'h0000_00AA);
    rd_a("R6 neighbour untouched", 3'd6, 2'b00);
    rd_a("R6 target changed", 3'd5, 2'b00);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd6; wr_sel = 2'b00; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    rd_a("R6 disabled write ignored", 3'd6, 2'b00);
  endtask

  task automatic t_dual;
    @(negedge clk);
    ra_idx = 3'd3; ra_sel = 2'b11; rb_idx = 3'd5; rb_sel = 2'b01;
    #1;
    check("R9 port A", ra_data, exp_view(mdl[3], 2'b11));
    check("R9 port B", rb_data, exp_view(mdl[5], 2'b01));
    rb_idx = 3'd2; rb_sel = 2'b10;
    #1;
    check("R9 port A unaffected by B", ra_data, exp_view(mdl[3], 2'b11));
    check("R9 port B moved", rb_data, exp_view(mdl[2], 2'b10));
  endtask

  task automatic t_no_bypass;
    logic [31:0] old;
    old = mdl[7];
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_sel = 2'b00; wr_data = 32'h7777_0001;
    ra_idx = 3'd7; ra_sel = 2'b00;
    #1;
    check("R10 old value before edge", ra_data, old);
    @(posedge clk); #1;
    check("R10 new value after edge", ra_data, 32'h7777_0001);
    @(negedge clk); wr_en = 1'b0;
    mdl[7] = 32'h7777_0001;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word();
    t_half();
    t_bytes();
    t_isolation();
    t_dual();
    t_no_bypass();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule